// File: doc/BRIEF.md
# PLL power-up sequencer

This block walks a clock-synthesis PLL through its power-up and power-down steps by issuing writes to two registers of the PLL: a control register and a divider register. A host raises a one-cycle enable request together with the divider word, a requested control word and a port-select mask. The sequencer then clears control, loads the divider, writes a control word with the clock gates of the selected ports open, waits a minimum settle time, sets the oscillator enable bit and watches the lock input until the PLL locks or a timeout expires.

A disable request performs one read-modify-write of the control word. It clears the oscillator enable bit, closes the regulator gate, and then waits, within a second and shorter timeout, for the lock input to fall. An enable request that arrives while the last control word written still has the oscillator enable bit set first switches the oscillator off and then runs the full enable sequence. All delays are counted in clock cycles from a clock-frequency parameter. The sequencer keeps a copy of the last control word it wrote, so that its read-modify-writes need no read port.

Top module: `pll_pwr_seq`

## Requirements
- R1: After reset, reg_wr, busy, locked and timeout_err are all 0.
- R2: An accepted enable writes on consecutive cycles: control (reg_sel=0) with data 0, then divider (reg_sel=1) with the captured div_word, then control with the gated word.
- R3: The gated word is ctl_word with bit 31 (oscillator enable) and bit 30 (regulator gate) cleared, and bit i equal to port_sel[i] for each port (port 0 at bit 0, port 1 at bit 1).
- R4: The control write that sets bit 31, with all other bits equal to the gated word, comes exactly SETTLE_CYC+1 cycles after the gated-word write, with no write in between. SETTLE_CYC is SETTLE_NS converted to cycles and rounded up.
- R5: If pll_lock is first sampled high d cycles after the oscillator write, where 1 <= d <= LOCK_CYC, then locked rises d+1 cycles after that write, busy falls with it and timeout_err stays 0.
- R6: If pll_lock stays low for LOCK_CYC cycles after the oscillator write, timeout_err rises LOCK_CYC+1 cycles after that write, with busy and locked low. timeout_err clears when the next request is accepted.
- R7: An accepted disable makes exactly one control write: the last control word with bit 31 cleared and bit 30 set. locked falls in that same cycle.
- R8: After a disable, busy stays high until pll_lock is sampled low. If pll_lock is still high UNLOCK_CYC cycles after the write, timeout_err is raised and busy falls.
- R9: An enable accepted while the last control word written has bit 31 set first writes that word with bit 31 cleared, and then runs the R2 sequence.
- R10: Requests that arrive while busy is high are ignored: the write sequence and its timing do not change.
- R11: When enable and disable are requested in the same cycle, the enable is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_req | input | 1 | One-cycle power-up request |
| dis_req | input | 1 | One-cycle power-down request |
| div_word | input | DATA_W | Divider register value, captured on acceptance |
| ctl_word | input | DATA_W | Requested control bits, captured on acceptance |
| port_sel | input | N_PORTS | Ports whose clock gate is opened |
| pll_lock | input | 1 | Lock status from the PLL |
| reg_wr | output | 1 | Register write strobe |
| reg_sel | output | 1 | Write target: 0 control, 1 divider |
| reg_wdata | output | DATA_W | Write data |
| busy | output | 1 | A sequence is in progress |
| locked | output | 1 | PLL locked and sequence complete |
| timeout_err | output | 1 | Last sequence ended on a timeout |

## Verification
The hardest cases to reach are the exact edges of the two timeout windows and the forced switch-off ahead of a re-enable. The first needs the lock input to move on precisely the last cycle that is polled, or one cycle later. The second needs a previous control word with the oscillator still on, which only a successful lock or an aborted poll leaves behind. The bench drives the lock input from a PLL model whose lock and unlock delays are set per operation, including values of exactly the window and the window plus one. It chains random enables and disables so that both the timed-out and the locked states feed later enables.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PREOFF,
    ST_CLR,
    ST_DIV,
    ST_GATE,
    ST_SETTLE,
    ST_VCO,
    ST_POLL,
    ST_ON,
    ST_OFF,
    ST_UNPOLL
  } seq_state_e;

  // Cycles needed to cover amount / unit_div seconds-scaled time, rounded up, at least 1.
  function automatic int unsigned cyc_ceil(longint unsigned amount, longint unsigned khz,
                                           longint unsigned unit_div);
    longint unsigned c;
    c = (amount * khz + unit_div - 1) / unit_div;
    if (c == 0) c = 1;
    return int'(c[31:0]);
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pll_seq_words.sv
module pll_seq_words #(
  parameter int DATA_W    = 32,
  parameter int N_PORTS   = 2,
  parameter int VCO_BIT   = 31,
  parameter int LDO_BIT   = 30,
  parameter int GATE_LSB  = 0
) (
  input  logic [DATA_W-1:0]  req_ctl,
  input  logic [N_PORTS-1:0] req_ports,
  input  logic [DATA_W-1:0]  shadow,
  output logic [DATA_W-1:0]  gate_word,
  output logic [DATA_W-1:0]  vco_word,
  output logic [DATA_W-1:0]  off_word,
  output logic [DATA_W-1:0]  pre_word
);
  localparam logic [DATA_W-1:0] VCO_MASK = DATA_W'(1) << VCO_BIT;
  localparam logic [DATA_W-1:0] LDO_MASK = DATA_W'(1) << LDO_BIT;

  logic [DATA_W-1:0] gate_mask;
  logic [DATA_W-1:0] gate_set;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_bit
      if (gi >= GATE_LSB && gi < GATE_LSB + N_PORTS) begin : g_gate
        assign gate_mask[gi] = 1'b1;
        assign gate_set[gi]  = req_ports[gi - GATE_LSB];
      end else begin : g_plain
        assign gate_mask[gi] = 1'b0;
        assign gate_set[gi]  = 1'b0;
      end
    end
  endgenerate

  function automatic logic [DATA_W-1:0] f_gated(logic [DATA_W-1:0] w, logic [DATA_W-1:0] m,
                                                logic [DATA_W-1:0] s);
    return (w & ~(VCO_MASK | LDO_MASK | m)) | s;
  endfunction

  function automatic logic [DATA_W-1:0] f_vco_on(logic [DATA_W-1:0] w);
    return w | VCO_MASK;
  endfunction

  function automatic logic [DATA_W-1:0] f_power_down(logic [DATA_W-1:0] w);
    return (w & ~VCO_MASK) | LDO_MASK;
  endfunction

  function automatic logic [DATA_W-1:0] f_vco_off(logic [DATA_W-1:0] w);
    return w & ~VCO_MASK;
  endfunction

  assign gate_word = f_gated(req_ctl, gate_mask, gate_set);
  assign vco_word  = f_vco_on(shadow);
  assign off_word  = f_power_down(shadow);
  assign pre_word  = f_vco_off(shadow);
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int SETTLE_CYC = 4,
  parameter int LOCK_CYC   = 16,
  parameter int UNLOCK_CYC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_req,
  input  logic             dis_req,
  input  logic             pll_lock,
  input  logic             vco_armed,
  input  logic             tmr_zero,
  output seq_state_e       st,
  output logic             accept,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             set_err
);
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] LOCK_LD   = CNT_W'(LOCK_CYC - 1);
  localparam logic [CNT_W-1:0] UNLOCK_LD = CNT_W'(UNLOCK_CYC - 1);

  seq_state_e nxt;

  always_comb begin
    nxt      = st;
    accept   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    set_err  = 1'b0;
    case (st)
      ST_IDLE, ST_ON: begin
        if (en_req) begin
          accept = 1'b1;
          nxt    = vco_armed ? ST_PREOFF : ST_CLR;
        end else if (dis_req) begin
          accept = 1'b1;
          nxt    = ST_OFF;
        end
      end
      ST_PREOFF: nxt = ST_CLR;
      ST_CLR:    nxt = ST_DIV;
      ST_DIV:    nxt = ST_GATE;
      ST_GATE: begin
        nxt      = ST_SETTLE;
        tmr_load = 1'b1;
        tmr_val  = SETTLE_LD;
      end
      ST_SETTLE: if (tmr_zero) nxt = ST_VCO;
      ST_VCO: begin
        nxt      = ST_POLL;
        tmr_load = 1'b1;
        tmr_val  = LOCK_LD;
      end
      ST_POLL: begin
        if (pll_lock) nxt = ST_ON;
        else if (tmr_zero) begin
          nxt     = ST_IDLE;
          set_err = 1'b1;
        end
      end
      ST_OFF: begin
        nxt      = ST_UNPOLL;
        tmr_load = 1'b1;
        tmr_val  = UNLOCK_LD;
      end
      ST_UNPOLL: begin
        if (!pll_lock) nxt = ST_IDLE;
        else if (tmr_zero) begin
          nxt     = ST_IDLE;
          set_err = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end
endmodule

// File: rtl/pll_pwr_seq.sv
module pll_pwr_seq
  import pll_seq_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int N_PORTS       = 2,
  parameter int CLK_KHZ       = 250000,
  parameter int SETTLE_NS     = 500,
  parameter int LOCK_TMO_US   = 20000,
  parameter int UNLOCK_TMO_US = 1000,
  parameter int VCO_BIT       = 31,
  parameter int LDO_BIT       = 30,
  parameter int GATE_LSB      = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_req,
  input  logic               dis_req,
  input  logic [DATA_W-1:0]  div_word,
  input  logic [DATA_W-1:0]  ctl_word,
  input  logic [N_PORTS-1:0] port_sel,
  input  logic               pll_lock,
  output logic               reg_wr,
  output logic               reg_sel,
  output logic [DATA_W-1:0]  reg_wdata,
  output logic               busy,
  output logic               locked,
  output logic               timeout_err
);
  localparam int SETTLE_CYC = int'(cyc_ceil(longint'(SETTLE_NS), longint'(CLK_KHZ), 64'd1000000));
  localparam int LOCK_CYC   = int'(cyc_ceil(longint'(LOCK_TMO_US), longint'(CLK_KHZ), 64'd1000));
  localparam int UNLOCK_CYC = int'(cyc_ceil(longint'(UNLOCK_TMO_US), longint'(CLK_KHZ), 64'd1000));
  localparam int MAX_CYC    = int'(max3(SETTLE_CYC, LOCK_CYC, UNLOCK_CYC));
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_DIV  = 1'b1;

  seq_state_e         st;
  logic               accept, tmr_load, tmr_zero, set_err;
  logic [CNT_W-1:0]   tmr_val;
  logic [DATA_W-1:0]  shadow_q, req_ctl_q, req_div_q;
  logic [N_PORTS-1:0] req_ports_q;
  logic [DATA_W-1:0]  gate_word, vco_word, off_word, pre_word;
  logic               err_q;

  // Named internal events, used by the bound checker.
  logic ev_gate_wr, ev_vco_wr, ev_accept;
  assign ev_gate_wr = (st == ST_GATE);
  assign ev_vco_wr  = (st == ST_VCO);
  assign ev_accept  = accept;

  pll_seq_fsm #(
    .CNT_W(CNT_W), .SETTLE_CYC(SETTLE_CYC), .LOCK_CYC(LOCK_CYC), .UNLOCK_CYC(UNLOCK_CYC)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req), .pll_lock(pll_lock),
    .vco_armed(shadow_q[VCO_BIT]), .tmr_zero(tmr_zero), .st(st), .accept(accept),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .set_err(set_err)
  );

  pll_seq_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  pll_seq_words #(
    .DATA_W(DATA_W), .N_PORTS(N_PORTS), .VCO_BIT(VCO_BIT), .LDO_BIT(LDO_BIT), .GATE_LSB(GATE_LSB)
  ) words_i (
    .req_ctl(req_ctl_q), .req_ports(req_ports_q), .shadow(shadow_q),
    .gate_word(gate_word), .vco_word(vco_word), .off_word(off_word), .pre_word(pre_word)
  );

  // Captured request and copy of the last control word written.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_ctl_q   <= '0;
      req_div_q   <= '0;
      req_ports_q <= '0;
      shadow_q    <= '0;
      err_q       <= 1'b0;
    end else begin
      if (accept) begin
        req_ctl_q   <= ctl_word;
        req_div_q   <= div_word;
        req_ports_q <= port_sel;
      end
      if (reg_wr && reg_sel == SEL_CTRL) shadow_q <= reg_wdata;
      if (set_err)     err_q <= 1'b1;
      else if (accept) err_q <= 1'b0;
    end
  end

  always_comb begin
    reg_wr    = 1'b1;
    reg_sel   = SEL_CTRL;
    reg_wdata = '0;
    case (st)
      ST_PREOFF: reg_wdata = pre_word;
      ST_CLR:    reg_wdata = '0;
      ST_DIV: begin
        reg_sel   = SEL_DIV;
        reg_wdata = req_div_q;
      end
      ST_GATE:   reg_wdata = gate_word;
      ST_VCO:    reg_wdata = vco_word;
      ST_OFF:    reg_wdata = off_word;
      default:   reg_wr    = 1'b0;
    endcase
  end

  assign busy        = (st != ST_IDLE) && (st != ST_ON);
  assign locked      = (st == ST_ON);
  assign timeout_err = err_q;
endmodule

// File: rtl/pll_pwr_seq_chk.sv
module pll_pwr_seq_chk #(
  parameter int DATA_W     = 32,
  parameter int VCO_BIT    = 31,
  parameter int SETTLE_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_sel,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              busy,
  input logic              locked,
  input logic              timeout_err,
  input logic              pll_lock,
  input logic              ev_gate_wr,
  input logic              ev_vco_wr
);
  int unsigned gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                   gap_q <= 32'hFFFF_FFFF;
    else if (ev_gate_wr)          gap_q <= 1;
    else if (gap_q != 32'hFFFF_FFFF) gap_q <= gap_q + 1;
  end

  // R2: a divider write is always preceded by a control clear
  a_r2_div_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel) |-> $past(reg_wr && !reg_sel && reg_wdata == '0));

  // R4: oscillator write lands exactly SETTLE_CYC+1 cycles after the gate write
  a_r4_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vco_wr |-> (gap_q == SETTLE_CYC + 1));

  // R5: locked only rises after the lock input was seen high
  a_r5_lock_seen: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(pll_lock));

  // R6: an error flag never coexists with an active or locked sequence
  a_r6_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> (!busy && !locked));

  // R7: leaving the locked state always writes control with the oscillator off
  a_r7_drop_writes: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> (reg_wr && !reg_sel && !reg_wdata[VCO_BIT]));
endmodule

bind pll_pwr_seq pll_pwr_seq_chk #(
  .DATA_W(DATA_W), .VCO_BIT(VCO_BIT), .SETTLE_CYC(SETTLE_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .busy(busy), .locked(locked), .timeout_err(timeout_err), .pll_lock(pll_lock),
  .ev_gate_wr(ev_gate_wr), .ev_vco_wr(ev_vco_wr)
);

// File: tb/pll_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module pll_pwr_seq_tb_top;
  localparam int CLK_KHZ = 250000;
  localparam int S_NS    = 500;
  localparam int L_US    = 4;
  localparam int U_US    = 2;
  // Bench's own cycle arithmetic: ns*MHz/1000 and us*MHz
  localparam int S_CYC = (S_NS * (CLK_KHZ / 1000) + 999) / 1000;
  localparam int L_CYC = L_US * (CLK_KHZ / 1000);
  localparam int U_CYC = U_US * (CLK_KHZ / 1000);
  localparam logic [31:0] VCO = 32'h8000_0000;
  localparam logic [31:0] LDO = 32'h4000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_req = 1'b0, dis_req = 1'b0;
  logic [31:0] div_word = '0, ctl_word = '0;
  logic [1:0]  port_sel = '0;
  logic pll_lock = 1'b0;
  logic reg_wr, reg_sel, busy, locked, timeout_err;
  logic [31:0] reg_wdata;

  always #2 clk = ~clk;

  pll_pwr_seq #(.CLK_KHZ(CLK_KHZ), .SETTLE_NS(S_NS), .LOCK_TMO_US(L_US), .UNLOCK_TMO_US(U_US))
  dut_i (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req), .div_word(div_word),
    .ctl_word(ctl_word), .port_sel(port_sel), .pll_lock(pll_lock), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .busy(busy), .locked(locked),
    .timeout_err(timeout_err)
  );

  int nchk = 0, nerr = 0, cyc = 0;
  bit done = 0;
  logic        wl_sel [64];
  logic [31:0] wl_dat [64];
  int          wl_cyc [64];
  int wn = 0;
  int lock_dly = -1, unlock_dly = -1, lk_cnt = -1, ul_cnt = -1;
  int lk_rise = -1, err_rise = -1, busy_fall = -1;
  logic prev_locked = 0, prev_err = 0, prev_busy = 0;
  logic [31:0] last_ctl = '0;

  // Write log, edge trackers and PLL model, all on the falling edge.
  always @(negedge clk) begin
    cyc++;
    if (rst_n && reg_wr && wn < 64) begin
      wl_sel[wn] = reg_sel; wl_dat[wn] = reg_wdata; wl_cyc[wn] = cyc; wn++;
    end
    if (locked && !prev_locked) lk_rise = cyc;
    if (timeout_err && !prev_err) err_rise = cyc;
    if (!busy && prev_busy) busy_fall = cyc;
    prev_locked = locked; prev_err = timeout_err; prev_busy = busy;
    if (rst_n && reg_wr && !reg_sel && reg_wdata[31]) begin
      pll_lock = 0; lk_cnt = lock_dly; ul_cnt = -1;
    end else if (rst_n && reg_wr && !reg_sel) begin
      lk_cnt = -1;
      if (pll_lock && ul_cnt < 0) ul_cnt = unlock_dly;
    end else begin
      if (lk_cnt > 0) begin lk_cnt--; if (lk_cnt == 0) begin pll_lock = 1; lk_cnt = -1; end end
      if (ul_cnt > 0) begin ul_cnt--; if (ul_cnt == 0) begin pll_lock = 0; ul_cnt = -1; end end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic e, input logic d, input bit clr);
    @(negedge clk); #1;
    if (clr) begin wn = 0; lk_rise = -1; err_rise = -1; busy_fall = -1; end
    en_req = e; dis_req = d;
    @(negedge clk); #1;
    en_req = 0; dis_req = 0;
  endtask

  task automatic wait_idle();
    int k = 0;
    while (busy && k < 5000) begin @(negedge clk); #1; k++; end
    check(!busy, "busy-stuck", busy, 0);
  endtask

  function automatic logic [31:0] gated(logic [31:0] c, logic [1:0] p);
    return (c & ~(VCO | LDO | 32'h3)) | {30'b0, p};
  endfunction

  // Enable (optionally with disable in the same cycle, R11); noise pulses test R10.
  task automatic run_en(input logic [31:0] dv, input logic [31:0] cw, input logic [1:0] ps,
                        input int dly, input bit both, input bit noise);
    logic [31:0] gw;
    int base, vc;
    base = last_ctl[31] ? 1 : 0;
    gw = gated(cw, ps);
    div_word = dv; ctl_word = cw; port_sel = ps; lock_dly = dly;
    pulse(1'b1, both, 1'b1);
    div_word = $urandom; ctl_word = $urandom; port_sel = 2'($urandom);
    if (noise) begin
      repeat (20) @(negedge clk);
      pulse(1'b1, 1'b1, 1'b0);
    end
    wait_idle();
    check(wn == base + 4, "R2 write count", wn, base + 4);
    if (base == 1) check(!wl_sel[0] && wl_dat[0] == (last_ctl & ~VCO), "R9 pre-off word", wl_dat[0], last_ctl & ~VCO);
    check(!wl_sel[base] && wl_dat[base] == 0, "R2 clear first", wl_dat[base], 0);
    check(wl_sel[base+1] && wl_dat[base+1] == dv, "R2 divider second", wl_dat[base+1], dv);
    check(!wl_sel[base+2] && wl_dat[base+2] == gw, "R3 gated word", wl_dat[base+2], gw);
    check(wl_dat[base+3] == (gw | VCO), "R4 oscillator word", wl_dat[base+3], gw | VCO);
    check(wl_cyc[base+3] - wl_cyc[base+2] == S_CYC + 1, "R4 settle gap",
          wl_cyc[base+3] - wl_cyc[base+2], S_CYC + 1);
    check(wl_cyc[base+1] - wl_cyc[base] == 1 && wl_cyc[base+2] - wl_cyc[base+1] == 1,
          "R2 consecutive", wl_cyc[base+2] - wl_cyc[base], 2);
    vc = wl_cyc[base+3];
    if (dly >= 1 && dly <= L_CYC) begin
      check(locked && !timeout_err, "R5 locked", {locked, timeout_err}, 2'b10);
      check(lk_rise == vc + dly + 1, "R5 lock latency", lk_rise - vc, dly + 1);
    end else begin
      check(!locked && timeout_err, "R6 timeout flag", {locked, timeout_err}, 2'b01);
      check(err_rise == vc + L_CYC + 1, "R6 timeout latency", err_rise - vc, L_CYC + 1);
    end
    last_ctl = gw | VCO;
  endtask

  task automatic run_dis(input int udly);
    logic [31:0] exp;
    bit was_high;
    int wc;
    was_high = pll_lock;
    unlock_dly = udly;
    exp = (last_ctl & ~VCO) | LDO;
    pulse(1'b0, 1'b1, 1'b1);
    check(!locked, "R7 locked cleared", locked, 0);
    wait_idle();
    check(wn == 1 && !wl_sel[0] && wl_dat[0] == exp, "R7 single write", wl_dat[0], exp);
    wc = wl_cyc[0];
    if (!was_high) check(busy_fall == wc + 2 && !timeout_err, "R8 already unlocked", busy_fall - wc, 2);
    else if (udly >= 1 && udly <= U_CYC)
      check(busy_fall == wc + udly + 1 && !timeout_err, "R8 unlock wait", busy_fall - wc, udly + 1);
    else
      check(timeout_err && busy_fall == wc + U_CYC + 1, "R8 unlock timeout", busy_fall - wc, U_CYC + 1);
    last_ctl = exp;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    check(!reg_wr && !busy && !locked && !timeout_err, "R1 reset state",
          {reg_wr, busy, locked, timeout_err}, 0);
    run_en(32'h0000_1234, 32'hC0F0_00FF, 2'b01, 10, 0, 0);
    run_en(32'h0000_0042, 32'h0000_0000, 2'b10, 5, 0, 0);      // R9 re-enable
    run_dis(20);
    run_en(32'h0001_0001, 32'h1234_5678, 2'b11, L_CYC, 0, 1);  // R5 edge, R10 noise
    run_dis(U_CYC);                                            // R8 edge
    run_en(32'h0000_00A5, 32'h0F0F_0F0F, 2'b00, L_CYC + 1, 0, 0); // R6 edge
    run_en(32'h0000_0077, 32'h8000_0003, 2'b01, 30, 1, 0);     // R11, R9, R6 clear
    run_dis(-1);                                               // R8 timeout
    run_en(32'h0000_0099, 32'h5555_AAAA, 2'b10, 3, 0, 0);
    for (int i = 0; i < 10; i++) begin
      if ($urandom_range(1, 0) == 1)
        run_en($urandom, $urandom, 2'($urandom), $urandom_range(400, 1), 0, 0);
      else
        run_dis($urandom_range(300, 1));
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule